// File: doc/BRIEF.md
# Protocol Operation Sequencer

This block is the top-level operating-mode sequencer of a time-triggered bus communication controller. It holds the controller in one of five modes: configuration, ready, normal-active, normal-passive and halted. From that mode it drives the enables for the receive path, the transmit path and clock synchronisation. The host steers it by writing 4-bit command words through a single write strobe. The protocol side feeds it an end-of-cycle strobe, a start request, the current error state and two counter values, each compared against a configured limit.

There are two ways to stop the controller. A halt command only raises a pending flag, and the halt takes effect at the next end of the communication cycle. A freeze command halts at once from any mode. Error inputs also move the block: it can degrade from active to passive, recover from passive to active, or stop completely. A halted controller keeps all its status bits for inspection until the host returns it to configuration. A command that the current mode does not accept is dropped and reported on a one-cycle reject flag.

Top module: `poc_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the block in CONFIG. The mode codes on `mode_o` are CONFIG=0, READY=1, NORMAL_ACTIVE=2, NORMAL_PASSIVE=3 and HALT=4. After reset all enables are low and all status flags are clear.
- R2: In CONFIG, the command 4'b0010 moves the block to READY. In READY, `start_req` moves it to NORMAL_ACTIVE.
- R3: All three enables are high in NORMAL_ACTIVE. In NORMAL_PASSIVE, receive and clock-sync are high and transmit is low. In every other mode all three enables are low.
- R4: The command 4'b0110, accepted in either normal mode, sets `halt_pend` on the next cycle without changing the mode. The mode becomes HALT on the first `cycle_end` sampled while `halt_pend` is already set.
- R5: The command 4'b0111 moves the block to HALT on the next cycle from every mode and sets `frozen`. It has priority over every other cause of transition, including a pending halt.
- R6: In NORMAL_ACTIVE, an error state other than ACTIVE moves the block to NORMAL_PASSIVE. The error codes are ACTIVE=2'b00, PASSIVE=2'b01 and COMM_HALT=2'b10.
- R7: In NORMAL_PASSIVE, error state COMM_HALT moves the block to HALT.
- R8: In NORMAL_PASSIVE, with error state ACTIVE, the block returns to NORMAL_ACTIVE only when `recover_cnt` equals `recover_limit` minus one. Otherwise it stays passive.
- R9: In either normal mode, `ccfail_cnt` greater than or equal to `fatal_limit` moves the block to HALT. This outranks every cause except freeze.
- R10: In NORMAL_PASSIVE, the command 4'b0010 moves the block to READY and clears `halt_pend`. A fatal count, COMM_HALT or a due deferred halt outranks it.
- R11: In HALT, only the command 4'b0001 leaves the mode; it goes to CONFIG and clears `halt_pend` and `frozen`. Start, strobes, error inputs and other commands leave the mode and the flags unchanged.
- R12: A written command that the current mode does not accept, or an unknown code, changes neither the mode nor the flags. It raises `cmd_reject` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_wr | input | 1 | Host command write strobe |
| cmd_code | input | 4 | Command word |
| cycle_end | input | 1 | End-of-communication-cycle strobe |
| start_req | input | 1 | Start request from READY |
| err_state | input | 2 | Error state code |
| ccfail_cnt | input | CNT_W | Clock-correction-failed count |
| fatal_limit | input | CNT_W | Fatal limit for that count |
| recover_cnt | input | CNT_W | Tracked count for passive-to-active recovery |
| recover_limit | input | CNT_W | Recovery limit |
| mode_o | output | 3 | Current mode code |
| rx_en | output | 1 | Receive enable |
| tx_en | output | 1 | Transmit enable |
| csync_en | output | 1 | Clock synchronisation enable |
| halt_pend | output | 1 | Deferred halt requested |
| frozen | output | 1 | Halt caused by freeze |
| cmd_reject | output | 1 | Previous write was rejected |

## Verification
Every result is due one clock after the edge that samples its cause: the mode, the enables that decode from it, both flags and the reject pulse. The one exception is the deferred halt, which takes two sampled events. The first edge sets `halt_pend`, and the mode changes one cycle after a later `cycle_end` edge. The bench drives inputs on the falling edge and compares all outputs on the next falling edge against a reference model stepped once per rising edge. Directed sequences cover each priority clash, and seeded random traffic then covers mixed inputs.

// File: rtl/poc_pkg.sv
package poc_pkg;

    typedef enum logic [2:0] {
        ST_CONFIG  = 3'd0,
        ST_READY   = 3'd1,
        ST_ACTIVE  = 3'd2,
        ST_PASSIVE = 3'd3,
        ST_HALT    = 3'd4
    } poc_state_e;

    typedef enum logic [1:0] {
        ERR_ACTIVE    = 2'b00,
        ERR_PASSIVE   = 2'b01,
        ERR_COMM_HALT = 2'b10,
        ERR_RSVD      = 2'b11
    } err_state_e;

    localparam logic [3:0] CMD_DEFCFG = 4'b0001;
    localparam logic [3:0] CMD_READY  = 4'b0010;
    localparam logic [3:0] CMD_HALT   = 4'b0110;
    localparam logic [3:0] CMD_FREEZE = 4'b0111;

    // decoded, legality-qualified command
    typedef struct packed {
        logic defcfg;
        logic ready;
        logic halt;
        logic freeze;
        logic illegal;
    } cmd_dec_t;

    typedef struct packed {
        logic rx;
        logic tx;
        logic csync;
    } bus_en_t;

    function automatic logic is_normal(poc_state_e s);
        return (s == ST_ACTIVE) || (s == ST_PASSIVE);
    endfunction

endpackage

// File: rtl/poc_cmd_decode.sv
module poc_cmd_decode
    import poc_pkg::*;
(
    input  poc_state_e state,
    input  logic       wr,
    input  logic [3:0] code,
    output cmd_dec_t   dec
);
    always_comb begin
        dec = '0;
        if (wr) begin
            case (code)
                CMD_FREEZE: dec.freeze = 1'b1;
                CMD_READY: begin
                    if (state == ST_CONFIG || state == ST_PASSIVE) dec.ready = 1'b1;
                    else                                           dec.illegal = 1'b1;
                end
                CMD_HALT: begin
                    if (is_normal(state)) dec.halt = 1'b1;
                    else                  dec.illegal = 1'b1;
                end
                CMD_DEFCFG: begin
                    if (state == ST_HALT) dec.defcfg = 1'b1;
                    else                  dec.illegal = 1'b1;
                end
                default: dec.illegal = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/poc_next_state.sv
module poc_next_state
    import poc_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  poc_state_e          state,
    input  cmd_dec_t            cmd,
    input  logic                cycle_end,
    input  logic                start_req,
    input  err_state_e          err,
    input  logic                halt_pend,
    input  logic [CNT_W-1:0]    ccfail_cnt,
    input  logic [CNT_W-1:0]    fatal_limit,
    input  logic [CNT_W-1:0]    recover_cnt,
    input  logic [CNT_W-1:0]    recover_limit,
    output poc_state_e          nxt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic fatal_hit;
    logic recover_hit;
    logic halt_due;

    assign fatal_hit   = (ccfail_cnt >= fatal_limit);
    assign recover_hit = (recover_cnt == (recover_limit - ONE));
    assign halt_due    = halt_pend && cycle_end;

    always_comb begin
        nxt = state;
        if (cmd.freeze) begin
            nxt = ST_HALT;
        end else begin
            case (state)
                ST_CONFIG:  if (cmd.ready) nxt = ST_READY;
                ST_READY:   if (start_req) nxt = ST_ACTIVE;
                ST_ACTIVE: begin
                    if (fatal_hit)              nxt = ST_HALT;
                    else if (halt_due)          nxt = ST_HALT;
                    else if (err != ERR_ACTIVE) nxt = ST_PASSIVE;
                end
                ST_PASSIVE: begin
                    if (fatal_hit)                           nxt = ST_HALT;
                    else if (err == ERR_COMM_HALT)           nxt = ST_HALT;
                    else if (halt_due)                       nxt = ST_HALT;
                    else if (cmd.ready)                      nxt = ST_READY;
                    else if (err == ERR_ACTIVE && recover_hit) nxt = ST_ACTIVE;
                end
                ST_HALT:    if (cmd.defcfg) nxt = ST_CONFIG;
                default:    nxt = ST_CONFIG;
            endcase
        end
    end
endmodule

// File: rtl/poc_enable_map.sv
module poc_enable_map
    import poc_pkg::*;
(
    input  poc_state_e state,
    output bus_en_t    en
);
    always_comb begin
        en = '0;
        case (state)
            ST_ACTIVE:  en = '{rx: 1'b1, tx: 1'b1, csync: 1'b1};
            ST_PASSIVE: en = '{rx: 1'b1, tx: 1'b0, csync: 1'b1};
            default:    en = '0;
        endcase
    end
endmodule

// File: rtl/poc_sequencer.sv
module poc_sequencer
    import poc_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [3:0]        cmd_code,
    input  logic              cycle_end,
    input  logic              start_req,
    input  logic [1:0]        err_state,
    input  logic [CNT_W-1:0]  ccfail_cnt,
    input  logic [CNT_W-1:0]  fatal_limit,
    input  logic [CNT_W-1:0]  recover_cnt,
    input  logic [CNT_W-1:0]  recover_limit,
    output logic [2:0]        mode_o,
    output logic              rx_en,
    output logic              tx_en,
    output logic              csync_en,
    output logic              halt_pend,
    output logic              frozen,
    output logic              cmd_reject
);
    poc_state_e state_q, state_d;
    cmd_dec_t   cmd;
    bus_en_t    en;
    logic       halt_q, frz_q, rej_q;
    logic       clear_flags_to_idle;

    poc_cmd_decode u_dec (
        .state (state_q),
        .wr    (cmd_wr),
        .code  (cmd_code),
        .dec   (cmd)
    );

    poc_next_state #(.CNT_W(CNT_W)) u_nxt (
        .state         (state_q),
        .cmd           (cmd),
        .cycle_end     (cycle_end),
        .start_req     (start_req),
        .err           (err_state_e'(err_state)),
        .halt_pend     (halt_q),
        .ccfail_cnt    (ccfail_cnt),
        .fatal_limit   (fatal_limit),
        .recover_cnt   (recover_cnt),
        .recover_limit (recover_limit),
        .nxt           (state_d)
    );

    poc_enable_map u_map (
        .state (state_q),
        .en    (en)
    );

    // leaving for a non-communicating mode drops the deferred halt
    assign clear_flags_to_idle = (state_d == ST_CONFIG) || (state_d == ST_READY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CONFIG;
            halt_q  <= 1'b0;
            frz_q   <= 1'b0;
            rej_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            halt_q  <= clear_flags_to_idle ? 1'b0 : (halt_q | cmd.halt);
            frz_q   <= (state_d == ST_CONFIG) ? 1'b0 : (frz_q | cmd.freeze);
            rej_q   <= cmd.illegal;
        end
    end

    assign mode_o     = state_q;
    assign rx_en      = en.rx;
    assign tx_en      = en.tx;
    assign csync_en   = en.csync;
    assign halt_pend  = halt_q;
    assign frozen     = frz_q;
    assign cmd_reject = rej_q;

endmodule

// File: rtl/poc_sequencer_chk.sv
module poc_sequencer_chk #(
    parameter int CNT_W = 8
)(
    input logic              clk,
    input logic              rst,
    input logic              cmd_wr,
    input logic [3:0]        cmd_code,
    input logic              cycle_end,
    input logic [1:0]        err_state,
    input logic [CNT_W-1:0]  ccfail_cnt,
    input logic [CNT_W-1:0]  fatal_limit,
    input logic [2:0]        mode_o,
    input logic              rx_en,
    input logic              tx_en,
    input logic              csync_en,
    input logic              halt_pend,
    input logic              frozen,
    input logic              cmd_reject
);
    localparam logic [2:0] M_ACTIVE  = 3'd2;
    localparam logic [2:0] M_PASSIVE = 3'd3;
    localparam logic [2:0] M_HALT    = 3'd4;

    logic in_normal;
    assign in_normal = (mode_o == M_ACTIVE) || (mode_o == M_PASSIVE);

    assert_freeze_halts_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_code == 4'b0111) |=> (mode_o == M_HALT && frozen));

    assert_tx_only_active_R3: assert property (@(posedge clk) disable iff (rst)
        tx_en |-> (mode_o == M_ACTIVE && rx_en && csync_en));

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (mode_o == M_HALT && !(cmd_wr && cmd_code == 4'b0001)) |=> (mode_o == M_HALT));

    assert_deferred_halt_R4: assert property (@(posedge clk) disable iff (rst)
        (in_normal && halt_pend && cycle_end) |=> (mode_o == M_HALT));

    assert_fatal_limit_R9: assert property (@(posedge clk) disable iff (rst)
        (in_normal && ccfail_cnt >= fatal_limit) |=> (mode_o == M_HALT));

    assert_comm_halt_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_o == M_PASSIVE && err_state == 2'b10) |=> (mode_o == M_HALT));

    assert_reject_needs_write_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_reject) |-> $past(cmd_wr));

endmodule

bind poc_sequencer poc_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr      (cmd_wr),
    .cmd_code    (cmd_code),
    .cycle_end   (cycle_end),
    .err_state   (err_state),
    .ccfail_cnt  (ccfail_cnt),
    .fatal_limit (fatal_limit),
    .mode_o      (mode_o),
    .rx_en       (rx_en),
    .tx_en       (tx_en),
    .csync_en    (csync_en),
    .halt_pend   (halt_pend),
    .frozen      (frozen),
    .cmd_reject  (cmd_reject)
);

// File: tb/sim_poc_sequencer.sv
`timescale 1ns/1ps
module sim_poc_sequencer;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         cmd_wr;
    logic [3:0]   cmd_code;
    logic         cycle_end;
    logic         start_req;
    logic [1:0]   err_state;
    logic [W-1:0] ccfail_cnt, fatal_limit, recover_cnt, recover_limit;
    logic [2:0]   mode_o;
    logic         rx_en, tx_en, csync_en, halt_pend, frozen, cmd_reject;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    logic [2:0] m_st;
    logic       m_halt, m_frz, m_rej;

    always #4 clk = ~clk;

    poc_sequencer #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .cycle_end(cycle_end), .start_req(start_req), .err_state(err_state),
        .ccfail_cnt(ccfail_cnt), .fatal_limit(fatal_limit),
        .recover_cnt(recover_cnt), .recover_limit(recover_limit),
        .mode_o(mode_o), .rx_en(rx_en), .tx_en(tx_en), .csync_en(csync_en),
        .halt_pend(halt_pend), .frozen(frozen), .cmd_reject(cmd_reject)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit legal(input logic [2:0] s, input logic [3:0] c);
        case (c)
            4'b0111: return 1'b1;
            4'b0010: return (s == 3'd0 || s == 3'd3);
            4'b0110: return (s == 3'd2 || s == 3'd3);
            4'b0001: return (s == 3'd4);
            default: return 1'b0;
        endcase
    endfunction

    // expected next mode per requirements, with the requirement that decided it
    task automatic predict(output logic [2:0] ns, output string why);
        bit wr_ok  = cmd_wr && legal(m_st, cmd_code);
        bit frz    = wr_ok && cmd_code == 4'b0111;
        bit rdy    = wr_ok && cmd_code == 4'b0010;
        bit fatal  = ccfail_cnt >= fatal_limit;
        bit due    = m_halt && cycle_end;
        bit recov  = recover_cnt == W'(recover_limit - 1);
        ns = m_st; why = "R12";
        if (frz) begin ns = 3'd4; why = "R5"; end
        else if (m_st == 3'd0) begin if (rdy) begin ns = 3'd1; why = "R2"; end end
        else if (m_st == 3'd1) begin if (start_req) begin ns = 3'd2; why = "R2"; end end
        else if (m_st == 3'd2) begin
            if (fatal) begin ns = 3'd4; why = "R9"; end
            else if (due) begin ns = 3'd4; why = "R4"; end
            else if (err_state != 2'b00) begin ns = 3'd3; why = "R6"; end
        end else if (m_st == 3'd3) begin
            if (fatal) begin ns = 3'd4; why = "R9"; end
            else if (err_state == 2'b10) begin ns = 3'd4; why = "R7"; end
            else if (due) begin ns = 3'd4; why = "R4"; end
            else if (rdy) begin ns = 3'd1; why = "R10"; end
            else if (err_state == 2'b00 && recov) begin ns = 3'd2; why = "R8"; end
            else why = "R8";
        end else begin
            why = "R11";
            if (wr_ok && cmd_code == 4'b0001) ns = 3'd0;
        end
    endtask

    task automatic tick(input string tag);
        logic [2:0] ns;
        string      why;
        bit         wr_ok;
        bit         hcmd, fcmd;
        predict(ns, why);
        wr_ok = cmd_wr && legal(m_st, cmd_code);
        hcmd  = wr_ok && cmd_code == 4'b0110;
        fcmd  = wr_ok && cmd_code == 4'b0111;
        @(posedge clk);
        m_halt = (ns == 3'd0 || ns == 3'd1) ? 1'b0 : (m_halt | hcmd);
        m_frz  = (ns == 3'd0) ? 1'b0 : (m_frz | fcmd);
        m_rej  = cmd_wr && !legal(m_st, cmd_code);
        m_st   = ns;
        @(negedge clk);
        if (tag == "") tag = why;
        chk(tag, "mode", int'(mode_o), int'(m_st));
        chk("R3", "rx_en", int'(rx_en), int'(m_st == 3'd2 || m_st == 3'd3));
        chk("R3", "tx_en", int'(tx_en), int'(m_st == 3'd2));
        chk("R3", "csync_en", int'(csync_en), int'(m_st == 3'd2 || m_st == 3'd3));
        chk("R4", "halt_pend", int'(halt_pend), int'(m_halt));
        chk("R5", "frozen", int'(frozen), int'(m_frz));
        chk("R12", "cmd_reject", int'(cmd_reject), int'(m_rej));
        cmd_wr = 1'b0; cycle_end = 1'b0; start_req = 1'b0;
    endtask

    task automatic cmd(input logic [3:0] c, input string tag);
        cmd_wr = 1'b1; cmd_code = c; tick(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        rst = 1'b1; cmd_wr = 1'b0; cmd_code = 4'd0; cycle_end = 1'b0; start_req = 1'b0;
        err_state = 2'b00; ccfail_cnt = '0; fatal_limit = 8'd10;
        recover_cnt = '0; recover_limit = 8'd5;
        m_st = 3'd0; m_halt = 1'b0; m_frz = 1'b0; m_rej = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "mode", int'(mode_o), 0);
        chk("R1", "enables", int'({rx_en, tx_en, csync_en}), 0);
        chk("R1", "flags", int'({halt_pend, frozen, cmd_reject}), 0);

        cmd(4'b0110, "R12");                 // halt not legal in CONFIG
        tick("R12");                          // reject lasts one cycle
        cmd(4'b1010, "R12");                 // unknown code
        cmd(4'b0010, "R2");
        start_req = 1'b1; tick("R2");
        // deferred halt
        cycle_end = 1'b1; cmd(4'b0110, "R4"); // same-cycle strobe does not halt
        tick("R4");
        cycle_end = 1'b1; tick("R4");
        // halt is sticky
        start_req = 1'b1; err_state = 2'b01; cycle_end = 1'b1; cmd(4'b0010, "R11");
        err_state = 2'b00;
        cmd(4'b0001, "R11");
        // passive and recovery
        cmd(4'b0010, "R2"); start_req = 1'b1; tick("R2");
        err_state = 2'b01; tick("R6");
        err_state = 2'b00; recover_cnt = 8'd3; tick("R8");
        recover_cnt = 8'd4; tick("R8");
        // freeze beats pending halt
        err_state = 2'b01; tick("R6");
        cmd(4'b0110, "R4");
        cycle_end = 1'b1; cmd(4'b0111, "R5");
        cmd(4'b0001, "R11");
        // fatal limit
        err_state = 2'b00; cmd(4'b0010, "R2"); start_req = 1'b1; tick("R2");
        ccfail_cnt = 8'd10; tick("R9");
        ccfail_cnt = 8'd0; cmd(4'b0001, "R11");
        // comm halt from passive
        cmd(4'b0010, "R2"); start_req = 1'b1; tick("R2");
        err_state = 2'b01; tick("R6");
        err_state = 2'b10; tick("R7");
        err_state = 2'b00; cmd(4'b0001, "R11");
        // ready from passive clears halt request
        cmd(4'b0010, "R2"); start_req = 1'b1; tick("R2");
        err_state = 2'b01; tick("R6");
        cmd(4'b0110, "R4");
        cmd(4'b0010, "R10");
        err_state = 2'b00;

        // seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom % 100;
            cmd_wr = (r < 35);
            r = $urandom % 10;
            case (r)
                0, 1:    cmd_code = 4'b0001;
                2, 3, 4: cmd_code = 4'b0010;
                5, 6:    cmd_code = 4'b0110;
                7:       cmd_code = ($urandom % 4 == 0) ? 4'b0111 : 4'b0010;
                default: cmd_code = 4'($urandom);
            endcase
            cycle_end = ($urandom % 5 == 0);
            start_req = ($urandom % 3 == 0);
            r = $urandom % 10;
            err_state = (r < 5) ? 2'b00 : (r < 8) ? 2'b01 : (r < 9) ? 2'b10 : 2'b11;
            ccfail_cnt    = 8'($urandom % 12);
            fatal_limit   = 8'd11;
            recover_limit = 8'($urandom % 4);
            recover_cnt   = 8'($urandom % 4);
            tick("");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule